// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is the digital control core of a four-way I2C bus switch. It behaves as an I2C target on one upstream clock/data pair and drives one enable line per downstream channel. A master addresses it, writes one control byte whose low bits pick which downstream channels are connected, and can read the byte back to learn the current selection. Any mix of channels may be on at once.

The upstream lines are oversampled by a system clock through two-flop synchronizers, and START, STOP and clock edges are found from the synchronized samples. SDA is driven as an open-drain pull-down request (`sda_pull` high means the line is pulled low). A freshly written selection waits inside the block and reaches the enable outputs only when the master ends the transfer with a STOP. This keeps every downstream line high at the moment it is connected.

Top module: `i2c_chan_sel`

## Requirements
- R1: Enable output `chan_en[k]` equals bit k of the control byte after a commit: 1 connects channel k, 0 disconnects it. Any combination is allowed.
- R2: In a write transfer every data byte after the address goes into the control byte. When several bytes are sent, only the last one remains.
- R3: `chan_en` changes only when a STOP (SDA rising while SCL is high) is seen. Writes and repeated STARTs leave it unchanged until then.
- R4: A read transfer returns all 8 bits of the control byte, most significant bit first. While the master acknowledges, the same byte is sent again.
- R5: Bit 0 of the address byte picks the direction: 1 reads and 0 writes. Bits 7..1 carry the 7-bit address, most significant bit first.
- R6: The address is 1110 followed by the strap bits `addr_strap[2:0]` (bit 2 first). On a mismatch SDA stays released, and later bytes are ignored until the next START.
- R7: While `rst_n` is low the control byte is cleared, the bus logic returns to idle, all channels are off and SDA is released.
- R8: The block pulls SDA low during the ninth clock after a matching address and after each written data byte.
- R9: In a read, a not-acknowledge from the master ends the transfer, and SDA then stays released.
- R10: A repeated START, even in the middle of a byte, restarts address reception. It does not commit a pending selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Upstream serial clock level |
| sda_i | input | 1 | Upstream serial data level (wired line) |
| addr_strap | input | 3 | Low three address bits from board straps |
| sda_pull | output | 1 | 1 pulls upstream SDA low |
| chan_en | output | NCH | Per-channel enable, bit k for channel k |

## Verification
The hardest case to reach is a selection that has been stored but not yet committed, followed by a repeated START. The stimulus writes a byte and then, without a STOP, issues a new START in the middle of a byte or reads the pending value back. The reference model compares the enables every cycle, so any early commit shows up at once. A reset that lands between the data byte and the STOP is driven the same way, to show that the pending byte is discarded.

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
  parameter logic [3:0] ADDR_HI = 4'b1110,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  input  logic [2:0]     addr_strap,
  output logic           sda_pull,
  output logic [NCH-1:0] chan_en
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [2:0] scl_p, sda_p;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ctrl;
  logic       rw, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl      = scl_p[1];
  wire sda      = sda_p[1];
  wire scl_rise = scl & ~scl_p[2];
  wire scl_fall = ~scl & scl_p[2];
  wire start    = scl & scl_p[2] & sda_p[2] & ~sda;
  wire stop     = scl & scl_p[2] & ~sda_p[2] & sda;
  wire addr_hit = sh[7:1] == {ADDR_HI, addr_strap};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      tx <= '0;
      ctrl <= '0;
      rw <= 1'b0;
      mack <= 1'b0;
      sda_pull <= 1'b0;
      chan_en <= '0;
    end else if (start) begin
      st <= S_ADDR;
      cnt <= '0;
      sda_pull <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE;
      sda_pull <= 1'b0;
      chan_en <= ctrl[NCH-1:0];
    end else begin
      case (st)
        S_ADDR, S_WR: begin
          if (scl_rise) begin
            sh <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == S_ADDR) begin
              if (addr_hit) begin
                rw <= sh[0];
                sda_pull <= 1'b1;
                st <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              ctrl <= sh;
              sda_pull <= 1'b1;
              st <= S_WACK;
            end
          end
        end
        S_AACK, S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda;
          end else if (scl_fall) begin
            if ((st == S_AACK && rw) || (st == S_RACK && mack)) begin
              sda_pull <= ~ctrl[7];
              tx <= {ctrl[6:0], 1'b0};
              cnt <= 4'd1;
              st <= S_RD;
            end else if (st == S_AACK) begin
              sda_pull <= 1'b0;
              cnt <= '0;
              st <= S_WR;
            end else begin
              sda_pull <= 1'b0;
              st <= S_IDLE;
            end
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt <= '0;
            st <= S_WR;
          end
        end
        S_RD: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_pull <= 1'b0;
              st <= S_RACK;
            end else begin
              sda_pull <= ~tx[7];
              tx <= {tx[6:0], 1'b0};
              cnt <= cnt + 4'd1;
            end
          end
        end
        default: sda_pull <= 1'b0;
      endcase
    end
endmodule

module i2c_chan_sel_chk #(parameter int NCH = 4) (
  input logic           clk,
  input logic           rst_n,
  input logic           scl_i,
  input logic           sda_i,
  input logic           sda_pull,
  input logic [NCH-1:0] chan_en,
  input logic [2:0]     st
);
  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_n |-> (chan_en == '0 && !sda_pull));

  assert_commit_on_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> (scl_i && sda_i));

  assert_pull_while_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_i);

  assert_idle_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |=> (!sda_pull || st != 3'd0));
endmodule

bind i2c_chan_sel i2c_chan_sel_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_pull(sda_pull), .chan_en(chan_en), .st(st)
);

// File: tb/tb_i2c_chan_sel.sv
module tb_i2c_chan_sel;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull;
  logic [3:0] chan_en;
  wire sda_line = sda_m & ~sda_pull;

  i2c_chan_sel dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(strap), .sda_pull(sda_pull), .chan_en(chan_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] exp_ctrl = 8'h00;
  logic [3:0] exp_chan = 4'h0;
  bit cmp_on = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (cmp_on) chk(chan_en == exp_chan, "R3 per-cycle enables", chan_en, exp_chan);

  task automatic wc(int n); repeat (n) @(negedge clk); endtask

  function automatic bit hit(logic [6:0] a); return a == {4'b1110, strap}; endfunction

  task automatic bstart;
    sda_m = 1'b1; wc(2); scl_m = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl_m = 1'b0; wc(2);
  endtask

  task automatic bstop;
    sda_m = 1'b0; wc(2); scl_m = 1'b1; wc(H);
    cmp_on = 1'b0; sda_m = 1'b1; wc(6);
    exp_chan = exp_ctrl[3:0]; cmp_on = 1'b1; wc(H);
  endtask

  task automatic bit_out(input bit b, output bit line);
    sda_m = b; wc(H); scl_m = 1'b1; wc(H/2); line = sda_line; wc(H/2); scl_m = 1'b0; wc(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit l;
    for (int i = 7; i >= 0; i--) bit_out(b[i], l);
    bit_out(1'b1, l);
    ack = !l;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    bit l;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin bit_out(1'b1, l); d = {d[6:0], l}; end
    bit_out(!give_ack, l);
  endtask

  task automatic write_bytes(input logic [6:0] a, input logic [7:0] b0, input logic [7:0] b1, input int n);
    bit ack;
    send_byte({a, 1'b0}, ack);
    chk(ack == hit(a), "R6 R5 R8 write address ack", ack, hit(a));
    send_byte(b0, ack);
    chk(ack == hit(a), "R8 data ack", ack, hit(a));
    if (hit(a)) exp_ctrl = b0;
    if (n > 1) begin
      send_byte(b1, ack);
      chk(ack == hit(a), "R2 R8 second data ack", ack, hit(a));
      if (hit(a)) exp_ctrl = b1;
    end
  endtask

  task automatic read_check(input logic [6:0] a, input int n);
    bit ack, l;
    logic [7:0] d;
    send_byte({a, 1'b1}, ack);
    chk(ack == 1'b1, "R5 R8 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      chk(d == exp_ctrl, "R4 read data", d, exp_ctrl);
    end
    bit_out(1'b1, l);
    chk(l == 1'b1, "R9 released after nack", l, 1);
    chk(sda_pull == 1'b0, "R9 pull after nack", sda_pull, 0);
  endtask

  initial begin
    bit ack, l;
    wc(3);
    chk(chan_en == 4'h0, "R7 reset enables", chan_en, 0);
    chk(sda_pull == 1'b0, "R7 reset sda", sda_pull, 0);
    rst_n = 1'b1; wc(3); cmp_on = 1'b1;

    bstart; write_bytes(7'h75, 8'h05, 8'h00, 1); bstop;
    chk(chan_en == 4'h5, "R1 channels 0 and 2", chan_en, 5);
    bstart; read_check(7'h75, 1); bstop;

    bstart; write_bytes(7'h75, 8'h0A, 8'hF3, 2); bstop;
    chk(chan_en == 4'h3, "R2 last byte kept", chan_en, 3);
    bstart; read_check(7'h75, 2); bstop;

    bstart; write_bytes(7'h7D, 8'h00, 8'h00, 2); bstop;
    chk(chan_en == 4'h3, "R6 upper bits mismatch ignored", chan_en, 3);
    bstart; write_bytes(7'h74, 8'h08, 8'h00, 1); bstop;
    chk(chan_en == 4'h3, "R6 strap mismatch ignored", chan_en, 3);

    strap = 3'b010;
    bstart; write_bytes(7'h72, 8'h0C, 8'h00, 1);
    bstart;
    chk(chan_en == 4'h3, "R10 repeated start no commit", chan_en, 3);
    read_check(7'h72, 1); bstop;
    chk(chan_en == 4'hC, "R10 commit at stop", chan_en, 12);

    bstart; send_byte({7'h72, 1'b0}, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b1, l);
    bstart; write_bytes(7'h72, 8'h06, 8'h00, 1); bstop;
    chk(chan_en == 4'h6, "R10 mid-byte restart", chan_en, 6);

    bstart; write_bytes(7'h72, 8'h09, 8'h00, 1);
    cmp_on = 1'b0; rst_n = 1'b0; wc(2);
    chk(chan_en == 4'h0, "R7 reset mid transfer enables", chan_en, 0);
    chk(sda_pull == 1'b0, "R7 reset mid transfer sda", sda_pull, 0);
    rst_n = 1'b1; exp_ctrl = 8'h00; exp_chan = 4'h0; wc(2);
    bstop;
    bstart; read_check(7'h72, 1); bstop;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule